// File: doc/BRIEF.md
# Stored-Program Byte Processor

This block is a small processor core built around a single 256-byte memory that holds both the program and its data. It has sixteen 8-bit general registers, a program counter and a 16-bit instruction register, and no accumulator. The core works in a fixed loop. It reads a 16-bit instruction out of two neighbouring memory bytes, latches the source registers, and then carries out one of the defined operations: load from memory, load immediate, store, register copy, wrapping add, bitwise OR/AND/XOR, rotate right, jump-if-equal-to-register-0 and stop. Each instruction takes exactly four clocks. A stop leaves the core parked with a status output raised.

Before reset is released, a test or boot agent fills memory through a load port. It reads memory back through a peek output that follows the same address. After the core stops, any register can be read through a dedicated select/data pair. The first instruction is fetched from the address in the `START_ADDR` parameter, which defaults to A0 hex.

The control is a five-state machine:
- **FETCH_HI** latches the upper instruction byte and advances the PC. It always moves to FETCH_LO.
- **FETCH_LO** latches the lower byte and advances the PC again. It always moves to DECODE.
- **DECODE** latches the two operand registers. It always moves to EXEC.
- **EXEC** writes the result or redirects the PC. It moves to FETCH_HI for a working opcode, or to HALT for a stopping opcode.
- **HALT** loops on itself until reset.

Top module: `stored_prog_cpu`

## Requirements
- R1: After reset the first fetch reads address `START_ADDR` (default A0). The byte at PC becomes instruction bits 15:8 and the byte at PC+1 becomes bits 7:0. The PC advances by 2 before the instruction executes.
- R2: Every instruction spends exactly four clocks, in the order FETCH_HI, FETCH_LO, DECODE, EXEC. For a program of one working instruction followed by a stop, `halted` is low after the 7th rising edge following reset release and high after the 8th.
- R3: Opcode 1 (bits 15:12), with destination field bits 11:8 and address field bits 7:0, loads the register from the memory byte at that address. Opcode 2 loads the register with bits 7:0 as an immediate value.
- R4: Opcode 3 writes the register named by bits 11:8 into the memory byte addressed by bits 7:0.
- R5: Opcode 5 writes (reg[bits 7:4] + reg[bits 3:0]) mod 256 into reg[bits 11:8]. No flags are kept.
- R6: Opcodes 7, 8 and 9 write the OR, AND and XOR, respectively, of reg[bits 7:4] and reg[bits 3:0] into reg[bits 11:8].
- R7: Opcode 4 copies reg[bits 7:4] into reg[bits 3:0].
- R8: Opcode A rotates reg[bits 11:8] right by (bits 3:0 mod 8) positions. A count of 0 or 8 leaves the value unchanged.
- R9: Opcode B loads the PC with bits 7:0 when reg[bits 11:8] equals register 0. Otherwise execution goes on with the next instruction.
- R10: Opcode C and the undefined opcodes 0, D, E and F stop the core. `halted` rises and stays high until reset, and no register or memory byte changes afterwards.
- R11: Opcode 6 changes no register and no memory byte, and execution continues.
- R12: An increment of the PC past FF wraps to 00.
- R13: While `rst_n` is low, `halted` is 0 and every register reads 0. A load-port write stores `load_data` at `load_addr` on the next rising edge, and `peek_data` shows the byte at `load_addr` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the core (memory is not cleared) |
| load_we | input | 1 | Load-port write strike; takes priority over a core store |
| load_addr | input | 8 | Load/peek byte address |
| load_data | input | 8 | Byte written by the load port |
| peek_data | output | 8 | Memory byte at `load_addr`, combinational |
| reg_sel | input | 4 | Register number for read-out |
| reg_data | output | 8 | Contents of register `reg_sel`, combinational |
| halted | output | 1 | High once a stopping opcode has executed |

## Verification
Results are checked only after the machine has parked. The exception is the four-clock instruction pace, which the bench counts edge by edge from reset release, sampling `halted` at the falling edge after the 7th and 8th rising edges. Register and memory values written in EXEC are visible one edge later. Reading them on falling edges once `halted` is high keeps every sample clear of that edge. Register and peek reads are combinational, so the bench sets the select and samples after a short settle delay, within the same low phase of the clock.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int SPC_AW   = 8;
    localparam int SPC_DW   = 8;
    localparam int SPC_REGS = 16;
    localparam int SPC_NIB  = 4;

    typedef enum logic [3:0] {
        OPC_RSV0 = 4'h0,
        OPC_LDM  = 4'h1,
        OPC_LDI  = 4'h2,
        OPC_STM  = 4'h3,
        OPC_MOV  = 4'h4,
        OPC_ADD  = 4'h5,
        OPC_NOP6 = 4'h6,
        OPC_OR   = 4'h7,
        OPC_AND  = 4'h8,
        OPC_XOR  = 4'h9,
        OPC_ROR  = 4'hA,
        OPC_JEQ  = 4'hB,
        OPC_HLT  = 4'hC,
        OPC_RSVD = 4'hD,
        OPC_RSVE = 4'hE,
        OPC_RSVF = 4'hF
    } opc_e;

    typedef enum logic [2:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_EXEC,
        ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_OR,
        ALU_AND,
        ALU_XOR,
        ALU_ROR
    } alu_sel_e;

endpackage

// File: rtl/spc_mem.sv
module spc_mem #(
    parameter int AW = spc_pkg::SPC_AW,
    parameter int DW = spc_pkg::SPC_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_wdata,
    output logic [DW-1:0] peek_data,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_we,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Load port wins when both sides strike in one cycle.
    always_ff @(posedge clk) begin
        if (pre_we) begin
            cells[pre_addr] <= pre_wdata;
        end else if (cpu_we) begin
            cells[cpu_addr] <= cpu_wdata;
        end
    end

    assign cpu_rdata = cells[cpu_addr];
    assign peek_data = cells[pre_addr];

    // R4: a core store is found in the addressed cell one edge later
    p_store_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && !pre_we) |=> (cells[$past(cpu_addr)] == $past(cpu_wdata)));

    // R13: a load-port write is found in the addressed cell one edge later
    p_preload_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> (cells[$past(pre_addr)] == $past(pre_wdata)));

endmodule

// File: rtl/spc_regfile.sv
module spc_regfile #(
    parameter int DW   = spc_pkg::SPC_DW,
    parameter int REGS = spc_pkg::SPC_REGS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(REGS)-1:0] ra_sel,
    output logic [DW-1:0]           ra_data,
    input  logic [$clog2(REGS)-1:0] rb_sel,
    output logic [DW-1:0]           rb_data,
    input  logic [$clog2(REGS)-1:0] dbg_sel,
    output logic [DW-1:0]           dbg_data,
    input  logic                    we,
    input  logic [$clog2(REGS)-1:0] wa,
    input  logic [DW-1:0]           wd
);

    logic [DW-1:0] regs [REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign ra_data  = regs[ra_sel];
    assign rb_data  = regs[rb_sel];
    assign dbg_data = regs[dbg_sel];

    // R3: a register write is visible on the next edge
    p_reg_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/spc_alu.sv
module spc_alu
    import spc_pkg::*;
#(
    parameter int DW = SPC_DW
) (
    input  alu_sel_e               sel,
    input  logic [DW-1:0]          a,
    input  logic [DW-1:0]          b,
    input  logic [$clog2(DW)-1:0]  amt,
    output logic [DW-1:0]          y
);

    localparam int DBL_W = 2 * DW;

    logic [DBL_W-1:0] ror_dbl;

    // Rotating the doubled word and keeping the low half yields a right rotation.
    assign ror_dbl = {a, a} >> amt;

    always_comb begin
        unique case (sel)
            ALU_ADD: y = a + b;
            ALU_OR:  y = a | b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            ALU_ROR: y = ror_dbl[DW-1:0];
            default: y = a;
        endcase
    end

endmodule

// File: rtl/stored_prog_cpu.sv
module stored_prog_cpu
    import spc_pkg::*;
#(
    parameter int                 AW         = SPC_AW,
    parameter int                 DW         = SPC_DW,
    parameter int                 REGS       = SPC_REGS,
    parameter logic [SPC_AW-1:0]  START_ADDR = 8'hA0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_we,
    input  logic [AW-1:0]           load_addr,
    input  logic [DW-1:0]           load_data,
    output logic [DW-1:0]           peek_data,
    input  logic [$clog2(REGS)-1:0] reg_sel,
    output logic [DW-1:0]           reg_data,
    output logic                    halted
);

    localparam int IW     = 2 * DW;
    localparam int RIDX_W = $clog2(REGS);
    localparam int ROT_W  = $clog2(DW);
    localparam int NIB    = SPC_NIB;

    cpu_state_e state, state_nxt;

    logic [AW-1:0]     pc;
    logic [IW-1:0]     ir;
    logic [DW-1:0]     opa, opb;

    opc_e              op;
    logic [RIDX_W-1:0] f_r, f_s, f_t;
    logic [AW-1:0]     f_xy;
    logic              stop_op;
    logic              jump_hit;

    logic [AW-1:0]     mem_addr;
    logic              mem_we;
    logic [DW-1:0]     mem_wd, mem_rd;

    logic [RIDX_W-1:0] ra_sel, rb_sel;
    logic [DW-1:0]     ra_data, rb_data;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_wa;
    logic [DW-1:0]     rf_wd;

    alu_sel_e          alu_sel;
    logic [DW-1:0]     alu_y;

    // Instruction fields
    assign op   = opc_e'(ir[IW-1 -: NIB]);
    assign f_r  = ir[3*NIB-1 -: RIDX_W];
    assign f_s  = ir[2*NIB-1 -: RIDX_W];
    assign f_t  = ir[NIB-1:0];
    assign f_xy = ir[AW-1:0];

    always_comb begin
        unique case (op)
            OPC_RSV0, OPC_HLT, OPC_RSVD, OPC_RSVE, OPC_RSVF: stop_op = 1'b1;
            default:                                         stop_op = 1'b0;
        endcase
    end

    assign jump_hit = (op == OPC_JEQ) && (opa == opb);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH_HI;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_FETCH_HI: state_nxt = ST_FETCH_LO;
            ST_FETCH_LO: state_nxt = ST_DECODE;
            ST_DECODE:   state_nxt = ST_EXEC;
            ST_EXEC:     state_nxt = stop_op ? ST_HALT : ST_FETCH_HI;
            ST_HALT:     state_nxt = ST_HALT;
            default:     state_nxt = ST_HALT;
        endcase
    end

    // Operand selection (consumed in DECODE)
    always_comb begin
        unique case (op)
            OPC_ADD, OPC_OR, OPC_AND, OPC_XOR, OPC_MOV: ra_sel = f_s;
            default:                                    ra_sel = f_r;
        endcase
        rb_sel = (op == OPC_JEQ) ? '0 : f_t;
    end

    always_comb begin
        unique case (op)
            OPC_OR:  alu_sel = ALU_OR;
            OPC_AND: alu_sel = ALU_AND;
            OPC_XOR: alu_sel = ALU_XOR;
            OPC_ROR: alu_sel = ALU_ROR;
            default: alu_sel = ALU_ADD;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        mem_addr = pc;
        mem_we   = 1'b0;
        mem_wd   = opa;
        rf_we    = 1'b0;
        rf_wa    = f_r;
        rf_wd    = alu_y;
        halted   = 1'b0;
        unique case (state)
            ST_FETCH_HI, ST_FETCH_LO, ST_DECODE: ;
            ST_EXEC: begin
                mem_addr = f_xy;
                unique case (op)
                    OPC_LDM: begin
                        rf_we = 1'b1;
                        rf_wd = mem_rd;
                    end
                    OPC_LDI: begin
                        rf_we = 1'b1;
                        rf_wd = f_xy;
                    end
                    OPC_STM: mem_we = 1'b1;
                    OPC_MOV: begin
                        rf_we = 1'b1;
                        rf_wa = f_t;
                        rf_wd = opa;
                    end
                    OPC_ADD, OPC_OR, OPC_AND, OPC_XOR, OPC_ROR: rf_we = 1'b1;
                    default: ;
                endcase
            end
            ST_HALT: halted = 1'b1;
            default: halted = 1'b1;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= START_ADDR;
            ir  <= '0;
            opa <= '0;
            opb <= '0;
        end else begin
            unique case (state)
                ST_FETCH_HI: begin
                    ir[IW-1:DW] <= mem_rd;
                    pc          <= pc + 1'b1;
                end
                ST_FETCH_LO: begin
                    ir[DW-1:0]  <= mem_rd;
                    pc          <= pc + 1'b1;
                end
                ST_DECODE: begin
                    opa <= ra_data;
                    opb <= rb_data;
                end
                ST_EXEC: begin
                    if (jump_hit) begin
                        pc <= f_xy;
                    end
                end
                default: ;
            endcase
        end
    end

    spc_mem #(.AW(AW), .DW(DW)) mem_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_we    (load_we),
        .pre_addr  (load_addr),
        .pre_wdata (load_data),
        .peek_data (peek_data),
        .cpu_addr  (mem_addr),
        .cpu_we    (mem_we),
        .cpu_wdata (mem_wd),
        .cpu_rdata (mem_rd)
    );

    spc_regfile #(.DW(DW), .REGS(REGS)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_sel   (ra_sel),
        .ra_data  (ra_data),
        .rb_sel   (rb_sel),
        .rb_data  (rb_data),
        .dbg_sel  (reg_sel),
        .dbg_data (reg_data),
        .we       (rf_we),
        .wa       (rf_wa),
        .wd       (rf_wd)
    );

    spc_alu #(.DW(DW)) alu_i (
        .sel (alu_sel),
        .a   (opa),
        .b   (opb),
        .amt (ir[ROT_W-1:0]),
        .y   (alu_y)
    );

    // R2: fixed four-state pace
    p_hi_then_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_HI) |=> (state == ST_FETCH_LO));
    p_decode_then_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (state == ST_EXEC));

    // R1: each fetch byte advances the PC by one (wrapping, R12)
    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_LO) |=> (pc == AW'($past(pc) + 1'b1)));

    // R9: a matching compare redirects the PC to the address field
    p_jump_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OPC_JEQ && opa == opb) |=> (pc == $past(f_xy)));

    // R10: stop is sticky and quiet
    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rf_we && !mem_we && $stable(pc)));

endmodule

// File: tb/stored_prog_cpu_tb_top.sv
`timescale 1ns/100ps
module stored_prog_cpu_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_we = 1'b0;
    logic [7:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic [7:0] peek_data;
    logic [3:0] reg_sel = '0;
    logic [7:0] reg_data;
    logic       halted;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    stored_prog_cpu dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data),
        .peek_data (peek_data),
        .reg_sel   (reg_sel),
        .reg_data  (reg_data),
        .halted    (halted)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Single-instruction vectors run between a fixed prologue
    // (A0: 2155 r1=55, A2: 22C3 r2=C3) and a stop at A6.
    localparam int NV = 14;
    localparam logic [15:0] V_INSTR [NV] = '{
        16'h5312, 16'h5311, 16'h7312, 16'h8312, 16'h9312, 16'h4012, 16'hA203,
        16'hA20B, 16'hA208, 16'hA101, 16'h6312, 16'h3140, 16'h13A0, 16'h23FF};
    localparam logic        V_ISMEM [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [7:0]  V_WHERE [NV] = '{
        8'h03, 8'h03, 8'h03, 8'h03, 8'h03, 8'h02, 8'h02,
        8'h02, 8'h02, 8'h01, 8'h03, 8'h40, 8'h03, 8'h03};
    // R5 wrap 55+C3, R5 55+55, R6 OR/AND/XOR, R7 move, R8 ror3/ror11/ror8/ror1,
    // R11 no-op, R4 store, R3 load from A0, R3 immediate
    localparam logic [7:0]  V_EXP   [NV] = '{
        8'h18, 8'hAA, 8'hD7, 8'h41, 8'h96, 8'h55, 8'h78,
        8'h78, 8'hC3, 8'hAA, 8'h00, 8'h55, 8'h21, 8'hFF};
    localparam int          V_REQ   [NV] = '{
        5, 5, 6, 6, 6, 7, 8, 8, 8, 8, 11, 4, 3, 3};

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        load_we   = 1'b1;
        load_addr = a;
        load_data = d;
        @(negedge clk);
        load_we   = 1'b0;
    endtask

    task automatic poke16(input logic [7:0] a, input logic [15:0] w);
        poke(a, w[15:8]);
        poke(a + 8'd1, w[7:0]);
    endtask

    task automatic prep();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) poke(i[7:0], 8'h00);
    endtask

    task automatic run(input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (halted) return;
        end
        chk({tag, " halt reached"}, {7'd0, halted}, 8'h01);
    endtask

    task automatic rd_reg(input logic [3:0] idx, output logic [7:0] v);
        reg_sel = idx;
        #0.5;
        v = reg_data;
    endtask

    task automatic rd_mem(input logic [7:0] a, output logic [7:0] v);
        load_addr = a;
        #0.5;
        v = peek_data;
    endtask

    initial begin
        logic [7:0] v;

        // R13: reset state
        prep();
        @(negedge clk);
        chk("R13 halted in reset", {7'd0, halted}, 8'h00);
        rd_reg(4'h5, v);
        chk("R13 reg5 in reset", v, 8'h00);
        poke(8'h33, 8'h5A);
        rd_mem(8'h33, v);
        chk("R13 load/peek", v, 8'h5A);

        // Vector table
        for (int k = 0; k < NV; k++) begin
            prep();
            poke16(8'hA0, 16'h2155);
            poke16(8'hA2, 16'h22C3);
            poke16(8'hA4, V_INSTR[k]);
            poke16(8'hA6, 16'hC000);
            run($sformatf("R%0d vec%0d", V_REQ[k], k));
            if (V_ISMEM[k]) rd_mem(V_WHERE[k], v);
            else            rd_reg(V_WHERE[k][3:0], v);
            chk($sformatf("R%0d vec%0d instr %04h", V_REQ[k], k, V_INSTR[k]), v, V_EXP[k]);
        end

        // R1 / R3 / R4 / R5: two-operand add through memory from A0
        prep();
        poke16(8'hA0, 16'h156C);
        poke16(8'hA2, 16'h166D);
        poke16(8'hA4, 16'h5056);
        poke16(8'hA6, 16'h306E);
        poke16(8'hA8, 16'hC000);
        poke(8'h6C, 8'h02);
        poke(8'h6D, 8'h03);
        run("R1 sum program");
        rd_mem(8'h6E, v);
        chk("R1 sum stored at 6E", v, 8'h05);
        rd_reg(4'h0, v);
        chk("R5 reg0 sum", v, 8'h05);

        // R9: jump taken
        prep();
        poke16(8'hA0, 16'h2105);
        poke16(8'hA2, 16'h2005);
        poke16(8'hA4, 16'hB1B0);
        poke16(8'hA6, 16'h22AA);
        poke16(8'hA8, 16'hC000);
        poke16(8'hB0, 16'h2377);
        poke16(8'hB2, 16'hC000);
        run("R9 taken");
        rd_reg(4'h3, v);
        chk("R9 taken target ran", v, 8'h77);
        rd_reg(4'h2, v);
        chk("R9 taken skipped", v, 8'h00);

        // R9: jump not taken
        prep();
        poke16(8'hA0, 16'h2105);
        poke16(8'hA2, 16'h2006);
        poke16(8'hA4, 16'hB1B0);
        poke16(8'hA6, 16'h22AA);
        poke16(8'hA8, 16'hC000);
        poke16(8'hB0, 16'h2377);
        poke16(8'hB2, 16'hC000);
        run("R9 not taken");
        rd_reg(4'h2, v);
        chk("R9 fall-through ran", v, 8'hAA);
        rd_reg(4'h3, v);
        chk("R9 target not run", v, 8'h00);

        // R12: PC wrap FF -> 00
        prep();
        poke16(8'hA0, 16'hB0FE);
        poke16(8'hFE, 16'h2155);
        poke16(8'h00, 16'hC000);
        run("R12 wrap");
        rd_reg(4'h1, v);
        chk("R12 instr at FE ran", v, 8'h55);
        chk("R12 halted after wrap", {7'd0, halted}, 8'h01);

        // R10: undefined opcodes stop, sticky and quiet
        for (int k = 0; k < 4; k++) begin
            logic [15:0] bad;
            bad = (k == 0) ? 16'h0123 : (k == 1) ? 16'hD000 : (k == 2) ? 16'hE111 : 16'hF222;
            prep();
            poke16(8'hA0, 16'h2111);
            poke16(8'hA2, bad);
            poke16(8'hA4, 16'h2222);
            poke16(8'hA6, 16'hC000);
            run("R10 undefined");
            repeat (40) @(negedge clk);
            chk($sformatf("R10 op %04h halted sticky", bad), {7'd0, halted}, 8'h01);
            rd_reg(4'h2, v);
            chk($sformatf("R10 op %04h stopped early", bad), v, 8'h00);
            rd_reg(4'h1, v);
            chk($sformatf("R10 op %04h prior kept", bad), v, 8'h11);
        end

        // R2: four clocks per instruction
        prep();
        poke16(8'hA0, 16'h2111);
        poke16(8'hA2, 16'hC000);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (7) @(negedge clk);
        chk("R2 halted after 7 edges", {7'd0, halted}, 8'h00);
        @(negedge clk);
        chk("R2 halted after 8 edges", {7'd0, halted}, 8'h01);

        // R13: reset clears the stop and the registers
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk("R13 reset clears halted", {7'd0, halted}, 8'h00);
        rd_reg(4'h1, v);
        chk("R13 reset clears reg1", v, 8'h00);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule